// File: doc/BRIEF.md
# Async NAND Strobe Timing Generator

This block shapes the active-low write and read strobes for a single data-phase cycle on an asynchronous parallel NAND bus. A controller pulses a start request together with a direction bit and, for writes, the byte to drive. The block waits for the flash ready line, then walks through a fixed sequence of timed phases. Every phase length comes from one byte-wide tick count, taken from two 32-bit timing words that are sampled when the request is accepted.

A write holds the write strobe low and then high while the data-out enable is on. It then drops the enable and waits out the strobe-to-busy extension. A read holds the read strobe low and then high. It captures the flash data bus a programmed access time after the strobe falls, and then waits for the flash to release the bus. A one-clock done pulse closes either cycle. Chip enable, command and address latch phases are handled elsewhere.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset both strobes are high (1), the data-out enable and done are low, and the captured read byte is zero.
- R2: The timing words are sampled only in the cycle a start is accepted. Word A bits [31:24] hold the ready-wait count, [23:16] the write-extension count, [15:8] the write-cycle count and [7:0] the write-high count. Word B bits [31:24] hold the access count, [23:16] the read-hold count, [15:8] the read-pulse count and [7:0] the read-extension count.
- R3: After a start, the ready-wait phase advances only on clocks where the ready input is 1, and it ends after ready-wait such clocks.
- R4: A write holds the write strobe low for (write-cycle minus write-high) clocks, or one clock when that difference is below one. It then holds the strobe high for write-high clocks, and then runs write-extension clocks.
- R5: The data-out enable is 1 exactly during the write-low and write-high phases, with the data-out bus equal to the byte latched at start. It is 0 throughout the write-extension phase and throughout every read.
- R6: A read holds the read strobe low for read-pulse clocks, then high for read-hold clocks, then runs read-extension clocks.
- R7: The read byte is sampled at the end of the access-th clock after the read strobe falls. If access exceeds read-pulse plus read-hold, it is sampled on the last read-hold clock instead.
- R8: A field value of zero acts as one clock.
- R9: Done is 1 for exactly one clock, the clock right after the last extension clock. Both strobes are high and the data-out enable is low while done is 1.
- R10: A start request arriving while a cycle is in progress is ignored. Its direction, data and timing words have no effect.
- R11: The write and read strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all tick counts are in periods of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one data-phase cycle (accepted only when idle) |
| is_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| wdata_i | input | 8 | Byte to drive during a write |
| timing_a_i | input | 32 | Ready-wait / write-extension / write-cycle / write-high counts |
| timing_b_i | input | 32 | Access / read-hold / read-pulse / read-extension counts |
| ready_i | input | 1 | Flash ready line, 1 = ready |
| flash_din_i | input | 8 | Flash data bus as seen by the controller |
| we_n_o | output | 1 | Active-low write strobe |
| re_n_o | output | 1 | Active-low read strobe |
| dout_en_o | output | 1 | Enable for the controller's data-out drivers |
| dout_o | output | 8 | Byte driven onto the data bus during a write |
| rdata_o | output | 8 | Byte captured during the last read |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
Two pairs of events can land on the same clock. The first is a new start request arriving in the middle of a busy cycle. The bench pokes start with the opposite direction and different timing words at the third clock of a write and of a read. It judges the result by unchanged strobe lengths, unchanged latency, a single done pulse and a strobe of the other kind never falling. The second is the read sample landing on the clock where the read-high phase ends: with an access count larger than pulse plus hold, the bench drives a per-clock numbered pattern onto the data bus and expects the value from the last hold clock.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
    parameter int TICK_W = 8;
    localparam int FIELDS = 4;
    localparam int CFG_W = FIELDS * TICK_W;

    typedef logic [TICK_W-1:0] tick_t;

    typedef struct packed {
        tick_t rdy;
        tick_t wext;
        tick_t wlo;
        tick_t whi;
        tick_t acc;
        tick_t rhold;
        tick_t rlo;
        tick_t rext;
    } ticks_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RDY,
        PH_WLO,
        PH_WHI,
        PH_WEXT,
        PH_RLO,
        PH_RHI,
        PH_REXT
    } phase_e;
endpackage

// File: rtl/nsg_timing_regs.sv
module nsg_timing_regs
    import nsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CFG_W-1:0] cfg_a_i,
    input  logic [CFG_W-1:0] cfg_b_i,
    output ticks_t           ticks_o
);
    localparam int NFIELD = 2 * FIELDS;

    typedef struct packed {
        logic [CFG_W-1:0] a;
        logic [CFG_W-1:0] b;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.a = cfg_a_i;
            cfg_d.b = cfg_b_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Unpack most-significant field first, then force a zero count to one tick.
    tick_t raw [NFIELD];
    tick_t eff [NFIELD];

    for (genvar i = 0; i < FIELDS; i++) begin : g_unpack
        assign raw[i]          = cfg_q.a[(FIELDS-i)*TICK_W-1 -: TICK_W];
        assign raw[FIELDS + i] = cfg_q.b[(FIELDS-i)*TICK_W-1 -: TICK_W];
    end

    for (genvar j = 0; j < NFIELD; j++) begin : g_clamp
        assign eff[j] = (raw[j] == '0) ? tick_t'(1) : raw[j];
    end

    // Write strobe stays low for whatever the write-high part leaves of the cycle.
    tick_t wlo_len;
    always_comb begin
        if (eff[2] > eff[3]) begin
            wlo_len = eff[2] - eff[3];
        end else begin
            wlo_len = tick_t'(1);
        end
    end

    always_comb begin
        ticks_o.rdy   = eff[0];
        ticks_o.wext  = eff[1];
        ticks_o.wlo   = wlo_len;
        ticks_o.whi   = eff[3];
        ticks_o.acc   = eff[4];
        ticks_o.rhold = eff[5];
        ticks_o.rlo   = eff[6];
        ticks_o.rext  = eff[7];
    end
endmodule

// File: rtl/nsg_phase_fsm.sv
module nsg_phase_fsm
    import nsg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_write_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ready_i,
    input  ticks_t            ticks_i,
    output logic              load_o,
    output logic              we_n_o,
    output logic              re_n_o,
    output logic              dout_en_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              done_o,
    output logic              rd_active_o,
    output logic              rd_last_o
);
    typedef struct packed {
        phase_e            phase;
        tick_t             cnt;
        logic              is_wr;
        logic [DATA_W-1:0] wdata;
        logic              we_n;
        logic              re_n;
        logic              doe;
        logic              done;
    } state_s;

    state_s st_d, st_q;
    tick_t  len;
    logic   last;

    always_comb begin
        case (st_q.phase)
            PH_RDY:  len = ticks_i.rdy;
            PH_WLO:  len = ticks_i.wlo;
            PH_WHI:  len = ticks_i.whi;
            PH_WEXT: len = ticks_i.wext;
            PH_RLO:  len = ticks_i.rlo;
            PH_RHI:  len = ticks_i.rhold;
            PH_REXT: len = ticks_i.rext;
            default: len = tick_t'(1);
        endcase
    end

    assign last = (st_q.cnt == (len - tick_t'(1)));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load_o    = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load_o     = 1'b1;
                    st_d.phase = PH_RDY;
                    st_d.cnt   = '0;
                    st_d.is_wr = is_write_i;
                    st_d.wdata = wdata_i;
                end
            end
            PH_RDY: begin
                if (ready_i) begin
                    if (last) begin
                        st_d.cnt   = '0;
                        st_d.phase = st_q.is_wr ? PH_WLO : PH_RLO;
                    end else begin
                        st_d.cnt = st_q.cnt + tick_t'(1);
                    end
                end
            end
            default: begin
                if (last) begin
                    st_d.cnt = '0;
                    case (st_q.phase)
                        PH_WLO:  st_d.phase = PH_WHI;
                        PH_WHI:  st_d.phase = PH_WEXT;
                        PH_RLO:  st_d.phase = PH_RHI;
                        PH_RHI:  st_d.phase = PH_REXT;
                        default: begin
                            st_d.phase = PH_IDLE;
                            st_d.done  = 1'b1;
                        end
                    endcase
                end else begin
                    st_d.cnt = st_q.cnt + tick_t'(1);
                end
            end
        endcase
        // Pin drivers follow the next phase so each strobe comes straight from a flop.
        st_d.we_n = (st_d.phase != PH_WLO);
        st_d.re_n = (st_d.phase != PH_RLO);
        st_d.doe  = (st_d.phase == PH_WLO) || (st_d.phase == PH_WHI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.we_n  <= 1'b1;
            st_q.re_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign we_n_o      = st_q.we_n;
    assign re_n_o      = st_q.re_n;
    assign dout_en_o   = st_q.doe;
    assign dout_o      = st_q.wdata;
    assign done_o      = st_q.done;
    assign rd_active_o = (st_q.phase == PH_RLO) || (st_q.phase == PH_RHI);
    assign rd_last_o   = (st_q.phase == PH_RHI) && last;

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n_o && !re_n_o));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (we_n_o && re_n_o && !dout_en_o));

    // R5
    doe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n_o |-> !dout_en_o);

    // R4
    we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> dout_en_o);
endmodule

// File: rtl/nsg_read_capture.sv
module nsg_read_capture
    import nsg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              last_i,
    input  tick_t             acc_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int EL_W = TICK_W + 1;

    typedef struct packed {
        logic [EL_W-1:0]   elapsed;
        logic              taken;
        logic [DATA_W-1:0] rdata;
    } cap_s;

    cap_s cap_d, cap_q;
    logic hit;

    assign hit = (cap_q.elapsed == {1'b0, acc_i - tick_t'(1)}) || last_i;

    always_comb begin
        cap_d = cap_q;
        if (!active_i) begin
            cap_d.elapsed = '0;
            cap_d.taken   = 1'b0;
        end else begin
            cap_d.elapsed = cap_q.elapsed + EL_W'(1);
            if (!cap_q.taken && hit) begin
                cap_d.taken = 1'b1;
                cap_d.rdata = din_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rdata_o = cap_q.rdata;

    // R7
    one_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && cap_q.taken) |=> $stable(rdata_o));
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nsg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_write_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CFG_W-1:0]  timing_a_i,
    input  logic [CFG_W-1:0]  timing_b_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] flash_din_i,
    output logic              we_n_o,
    output logic              re_n_o,
    output logic              dout_en_o,
    output logic [DATA_W-1:0] dout_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);
    ticks_t ticks;
    logic   load;
    logic   rd_active;
    logic   rd_last;

    nsg_timing_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .cfg_a_i (timing_a_i),
        .cfg_b_i (timing_b_i),
        .ticks_o (ticks)
    );

    nsg_phase_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .is_write_i  (is_write_i),
        .wdata_i     (wdata_i),
        .ready_i     (ready_i),
        .ticks_i     (ticks),
        .load_o      (load),
        .we_n_o      (we_n_o),
        .re_n_o      (re_n_o),
        .dout_en_o   (dout_en_o),
        .dout_o      (dout_o),
        .done_o      (done_o),
        .rd_active_o (rd_active),
        .rd_last_o   (rd_last)
    );

    nsg_read_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (rd_active),
        .last_i   (rd_last),
        .acc_i    (ticks.acc),
        .din_i    (flash_din_i),
        .rdata_o  (rdata_o)
    );
endmodule

// File: tb/nand_strobe_gen_test.sv
`timescale 1ns/1ps
module nand_strobe_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_write = 1'b0;
    logic [7:0]  wdata = '0;
    logic [31:0] timing_a = '0;
    logic [31:0] timing_b = '0;
    logic        ready = 1'b1;
    logic [7:0]  din = '0;
    logic        we_n, re_n, doe, done;
    logic [7:0]  dout, rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nand_strobe_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .is_write_i  (is_write),
        .wdata_i     (wdata),
        .timing_a_i  (timing_a),
        .timing_b_i  (timing_b),
        .ready_i     (ready),
        .flash_din_i (din),
        .we_n_o      (we_n),
        .re_n_o      (re_n),
        .dout_en_o   (doe),
        .dout_o      (dout),
        .rdata_o     (rdata),
        .done_o      (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic run_txn(input bit wr, input logic [7:0] wd, input logic [31:0] ta,
                           input logic [31:0] tb, input int stall, input int poke,
                           input string tag);
        int rdy, wext, wc, wh, wlo, acc, hold, rpl, rext, exp_lat, exp_k;
        int n, lat, lo_we, lo_re, hi_w, ext_w, post_r, dmis, k, dones, extra;
        bit seen_doe, seen_re, fin;
        rdy  = eff(ta[31:24]); wext = eff(ta[23:16]); wc = eff(ta[15:8]); wh = eff(ta[7:0]);
        acc  = eff(tb[31:24]); hold = eff(tb[23:16]); rpl = eff(tb[15:8]); rext = eff(tb[7:0]);
        wlo  = (wc > wh) ? wc - wh : 1;
        exp_lat = wr ? rdy + wlo + wh + wext + stall + 1 : rdy + rpl + hold + rext + stall + 1;
        exp_k = (acc < rpl + hold) ? acc : rpl + hold;
        n = 0; lat = 0; lo_we = 0; lo_re = 0; hi_w = 0; ext_w = 0; post_r = 0; dmis = 0; k = 0;
        seen_doe = 0; seen_re = 0; fin = 0; dones = 0; extra = 0;
        @(negedge clk);
        timing_a = ta; timing_b = tb; is_write = wr; wdata = wd;
        ready = (stall == 0); start = 1'b1; din = '0;
        while (!fin && n < 2000) begin
            @(negedge clk);
            n++;
            if (!we_n) lo_we++;
            if (doe && we_n) hi_w++;
            if (doe && dout != wd) dmis++;
            if (doe) seen_doe = 1;
            if (!doe && seen_doe && !done) ext_w++;
            if (!re_n) begin lo_re++; seen_re = 1; end
            if (re_n && seen_re && !done) post_r++;
            if (done) begin fin = 1; lat = n; dones++; end
            if (!re_n || k > 0) k++;
            din = (k > 0) ? 8'(8'hA0 + k) : 8'h00;
            ready = (n > stall);
            if (poke != 0 && n == poke) begin
                start = 1'b1; is_write = !wr; wdata = ~wd;
                timing_a = 32'h0101_0101; timing_b = 32'h0101_0101;
            end else if (poke != 0 && n == poke + 1) begin
                start = 1'b0; is_write = wr; wdata = wd; timing_a = ta; timing_b = tb;
            end else if (n == 1) begin
                start = 1'b0;
            end
        end
        din = '0; ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done) dones++;
            if (!we_n || !re_n || doe) extra++;
        end
        // R9 latency and single done pulse
        chk(lat == exp_lat, {tag, " R9 latency"}, lat, exp_lat);
        chk(dones == 1, {tag, " R9 done count"}, dones, 1);
        // R10 nothing starts after the cycle ends
        chk(extra == 0, {tag, " R10 quiet after done"}, extra, 0);
        if (wr) begin
            chk(lo_we == wlo, {tag, " R4 write low"}, lo_we, wlo);
            chk(hi_w == wh, {tag, " R4 write high"}, hi_w, wh);
            chk(ext_w == wext, {tag, " R5 enable off in extension"}, ext_w, wext);
            chk(dmis == 0, {tag, " R5 data-out byte"}, dmis, 0);
            chk(lo_re == 0, {tag, " R11 no read strobe"}, lo_re, 0);
        end else begin
            chk(lo_re == rpl, {tag, " R6 read low"}, lo_re, rpl);
            chk(post_r == hold + rext, {tag, " R6 read high+extension"}, post_r, hold + rext);
            chk(lo_we == 0 && !seen_doe, {tag, " R5 no write activity"}, lo_we, 0);
            chk(int'(rdata) == 'hA0 + exp_k, {tag, " R7 captured byte"}, int'(rdata), 'hA0 + exp_k);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R1
        chk(we_n && re_n && !doe && !done, "R1 reset strobes", {we_n, re_n, doe, done}, 4'b1100);
        chk(rdata == 8'h00, "R1 reset read byte", int'(rdata), 0);
    endtask

    task automatic t_write_basic();
        run_txn(1'b1, 8'h5A, 32'h0302_0703, 32'h0, 0, 0, "write R2");
    endtask

    task automatic t_read_basic();
        run_txn(1'b0, 8'h00, 32'h0300_0000, 32'h0302_0403, 0, 0, "read R2");
    endtask

    task automatic t_read_late_access();
        run_txn(1'b0, 8'h00, 32'h0200_0000, 32'h0902_0401, 0, 0, "late access R7");
    endtask

    task automatic t_write_short_cycle();
        run_txn(1'b1, 8'hC3, 32'h0201_0205, 32'h0, 0, 0, "short cycle R4");
    endtask

    task automatic t_zero_fields();
        run_txn(1'b1, 8'h11, 32'h0, 32'h0, 0, 0, "zero write R8");
        run_txn(1'b0, 8'h00, 32'h0, 32'h0, 0, 0, "zero read R8");
    endtask

    task automatic t_ready_stall();
        run_txn(1'b1, 8'h77, 32'h0202_0502, 32'h0, 5, 0, "stall write R3");
        run_txn(1'b0, 8'h00, 32'h0100_0000, 32'h0201_0302, 3, 0, "stall read R3");
    endtask

    task automatic t_busy_ignore();
        run_txn(1'b1, 8'hE1, 32'h0302_0703, 32'h0, 0, 3, "busy write R10");
        run_txn(1'b0, 8'h00, 32'h0300_0000, 32'h0302_0403, 0, 3, "busy read R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write_basic();
        t_read_basic();
        t_read_late_access();
        t_write_short_cycle();
        t_zero_fields();
        t_ready_stall();
        t_busy_ignore();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule